// File: doc/BRIEF.md
# Nibble-Prefixed Instruction Decoder with Three-Level Evaluation Stack

This block takes one byte-wide instruction per clock whenever a valid strobe is high and decodes it. The upper nibble picks a direct function. The lower nibble is a 4-bit data field. Wide constants and large operation numbers are built up 4 bits at a time. Positive and negative prefix instructions accumulate these nibbles in an internal operand register. The register is wiped after any instruction that is not a prefix.

The decoded operations act on a push-down evaluation stack with three visible levels, called A (top), B and C. Loading a constant pushes the completed operand onto the stack. The operate function treats the completed operand as an indirect operation number. Two indirect operations are defined: one exchanges A and B, and the other pushes the most negative word value. Any code that is not defined raises a one-cycle error pulse and leaves the stack alone.

A surrounding fetch unit drives the byte stream and reads the instruction pointer. The data path reads the stack levels.

Top module: `nibble_stack_decoder`

## Requirements
- R1: After reset the instruction pointer equals the START_ADDR parameter, A, B, C and the operand register are zero, and both flag outputs are low.
- R2: Each clock edge with `instr_valid` high adds exactly one to the instruction pointer. A clock edge with `instr_valid` low changes nothing: not the pointer, not A/B/C, not the operand being assembled. Both flags are low in the following cycle.
- R3: Direct code 0x4 (load constant) pushes the current operand onto the stack: A takes the operand, B takes the old A, C takes the old B, and the old C is discarded.
- R4: Direct code 0x2 (positive prefix) replaces the low nibble of the operand register with its data field and then shifts the register left by 4. A chain of such prefixes followed by a load constant with data d yields the prefix nibbles in order, followed by d.
- R5: Direct code 0x6 (negative prefix) replaces the low nibble with its data field, shifts left by 4, and then inverts every bit of the operand register. Negative prefix 0 followed by load constant 5 yields 0xFFFFFFF5.
- R6: After any valid instruction other than a prefix, the operand register is zero. A following load constant with no prefix therefore yields just its own 4-bit field.
- R7: Direct code 0xF (operate) with operand 0 exchanges A and B, keeps C, and pulses `indirect_fire` high for one cycle.
- R8: Operate with operand 0x42 (positive prefix 4, then operate 2) pushes 0x80000000 onto the stack and pulses `indirect_fire`.
- R9: A direct code other than 0x2, 0x4, 0x6 and 0xF leaves A, B and C unchanged and still advances the pointer. It pulses `illegal_op` for one cycle.
- R10: Operate with an operand other than 0 or 0x42 leaves A, B and C unchanged and pulses both `illegal_op` and `indirect_fire` for one cycle.
- R11: A prefix instruction leaves A, B and C unchanged and raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_byte | input | 8 | Instruction: function in [7:4], data in [3:0] |
| instr_valid | input | 1 | Instruction byte is consumed on this edge |
| ip | output | ADDR_W | Instruction pointer |
| reg_a | output | WORD_W | Stack top (A) |
| reg_b | output | WORD_W | Second stack level (B) |
| reg_c | output | WORD_W | Third stack level (C) |
| indirect_fire | output | 1 | One-cycle pulse after an operate instruction |
| illegal_op | output | 1 | One-cycle pulse after an undefined direct or indirect code |

## Verification
Constants are loaded with no prefix, behind chains of two positive prefixes, behind a lone negative prefix, and behind a mixed positive-then-negative chain. Together these separate the nibble-replace, shift and invert ordering: each wrong ordering gives a different word. Four back-to-back loads show the loss of the oldest stack level. Idle cycles placed inside a prefix chain show that the partial operand survives a gap. Loads that follow an operate, an undefined code or a load show that the operand was cleared. Swap, most-negative load, an undefined operate number and an undefined direct code are applied to a stack holding distinct values, so any misplaced write shows up.

// File: rtl/nsd_pkg.sv
package nsd_pkg;

  typedef enum logic [3:0] {
    FN_PFIX = 4'h2,
    FN_LDC  = 4'h4,
    FN_NFIX = 4'h6,
    FN_OPR  = 4'hF
  } direct_fn_e;

  localparam int unsigned IND_SWAP = 32'h00;
  localparam int unsigned IND_MINT = 32'h42;

  typedef enum logic [1:0] {
    SOP_HOLD = 2'd0,
    SOP_PUSH = 2'd1,
    SOP_SWAP = 2'd2
  } stack_op_e;

  typedef enum logic {
    PSEL_OPERAND = 1'b0,
    PSEL_MININT  = 1'b1
  } push_sel_e;

endpackage

// File: rtl/nsd_operand.sv
module nsd_operand #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [3:0]        nib,
  input  logic              is_pfix,
  input  logic              is_nfix,
  output logic [WORD_W-1:0] cur_operand,
  output logic [WORD_W-1:0] oreg_q
);

  localparam int NIB_W = 4;

  function automatic logic [WORD_W-1:0] merge_nib(input logic [WORD_W-1:0] r,
                                                  input logic [NIB_W-1:0] d);
    return {r[WORD_W-1:NIB_W], d};
  endfunction

  function automatic logic [WORD_W-1:0] pos_step(input logic [WORD_W-1:0] v);
    return v << NIB_W;
  endfunction

  function automatic logic [WORD_W-1:0] neg_step(input logic [WORD_W-1:0] v);
    return ~(v << NIB_W);
  endfunction

  logic [WORD_W-1:0] oreg_d;

  assign cur_operand = merge_nib(oreg_q, nib);

  always_comb begin
    oreg_d = oreg_q;
    if (step) begin
      if (is_pfix)      oreg_d = pos_step(cur_operand);
      else if (is_nfix) oreg_d = neg_step(cur_operand);
      else              oreg_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) oreg_q <= '0;
    else        oreg_q <= oreg_d;
  end

endmodule

// File: rtl/nsd_decode.sv
module nsd_decode
  import nsd_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              step,
  input  logic [3:0]        fn,
  input  logic [WORD_W-1:0] cur_operand,
  output logic              is_pfix,
  output logic              is_nfix,
  output stack_op_e         stack_op,
  output push_sel_e         push_sel,
  output logic              opr_hit,
  output logic              bad_code
);

  always_comb begin
    is_pfix  = 1'b0;
    is_nfix  = 1'b0;
    stack_op = SOP_HOLD;
    push_sel = PSEL_OPERAND;
    opr_hit  = 1'b0;
    bad_code = 1'b0;
    if (step) begin
      case (fn)
        FN_PFIX: is_pfix = 1'b1;
        FN_NFIX: is_nfix = 1'b1;
        FN_LDC:  stack_op = SOP_PUSH;
        FN_OPR: begin
          opr_hit = 1'b1;
          if (cur_operand == WORD_W'(IND_SWAP)) begin
            stack_op = SOP_SWAP;
          end else if (cur_operand == WORD_W'(IND_MINT)) begin
            stack_op = SOP_PUSH;
            push_sel = PSEL_MININT;
          end else begin
            bad_code = 1'b1;
          end
        end
        default: bad_code = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/nsd_stack.sv
module nsd_stack
  import nsd_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  stack_op_e                    op,
  input  logic [WORD_W-1:0]            push_val,
  output logic [DEPTH-1:0][WORD_W-1:0] levels
);

  logic [WORD_W-1:0] lvl_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
    if (i == 0) begin : g_top
      always_ff @(posedge clk) begin
        if (!rst_n) lvl_q[i] <= '0;
        else begin
          case (op)
            SOP_PUSH: lvl_q[i] <= push_val;
            SOP_SWAP: lvl_q[i] <= lvl_q[1];
            default:  lvl_q[i] <= lvl_q[i];
          endcase
        end
      end
    end else if (i == 1) begin : g_second
      always_ff @(posedge clk) begin
        if (!rst_n) lvl_q[i] <= '0;
        else begin
          case (op)
            SOP_PUSH: lvl_q[i] <= lvl_q[0];
            SOP_SWAP: lvl_q[i] <= lvl_q[0];
            default:  lvl_q[i] <= lvl_q[i];
          endcase
        end
      end
    end else begin : g_deep
      always_ff @(posedge clk) begin
        if (!rst_n)              lvl_q[i] <= '0;
        else if (op == SOP_PUSH) lvl_q[i] <= lvl_q[i-1];
      end
    end
    assign levels[i] = lvl_q[i];
  end

endmodule

// File: rtl/nibble_stack_decoder.sv
module nibble_stack_decoder
  import nsd_pkg::*;
#(
  parameter int                WORD_W     = 32,
  parameter int                ADDR_W     = 32,
  parameter int                DEPTH      = 3,
  parameter logic [ADDR_W-1:0] START_ADDR = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        instr_byte,
  input  logic              instr_valid,
  output logic [ADDR_W-1:0] ip,
  output logic [WORD_W-1:0] reg_a,
  output logic [WORD_W-1:0] reg_b,
  output logic [WORD_W-1:0] reg_c,
  output logic              indirect_fire,
  output logic              illegal_op
);

  localparam logic [WORD_W-1:0] MIN_WORD = {1'b1, {(WORD_W-1){1'b0}}};

  logic [3:0]        fn_nib;
  logic [3:0]        data_nib;
  logic [WORD_W-1:0] cur_operand;
  logic [WORD_W-1:0] oreg_q;
  logic              is_pfix;
  logic              is_nfix;
  logic              is_prefix;
  stack_op_e         stack_op;
  push_sel_e         push_sel;
  logic              opr_hit;
  logic              bad_code;
  logic              push_en;
  logic              swap_en;
  logic [WORD_W-1:0] push_val;
  logic [DEPTH-1:0][WORD_W-1:0] levels;
  logic [ADDR_W-1:0] ip_q;
  logic              fire_q;
  logic              bad_q;

  assign fn_nib    = instr_byte[7:4];
  assign data_nib  = instr_byte[3:0];
  assign is_prefix = is_pfix | is_nfix;
  assign push_en   = (stack_op == SOP_PUSH);
  assign swap_en   = (stack_op == SOP_SWAP);
  assign push_val  = (push_sel == PSEL_MININT) ? MIN_WORD : cur_operand;

  nsd_operand #(.WORD_W(WORD_W)) u_operand (
    .clk         (clk),
    .rst_n       (rst_n),
    .step        (instr_valid),
    .nib         (data_nib),
    .is_pfix     (is_pfix),
    .is_nfix     (is_nfix),
    .cur_operand (cur_operand),
    .oreg_q      (oreg_q)
  );

  nsd_decode #(.WORD_W(WORD_W)) u_decode (
    .step        (instr_valid),
    .fn          (fn_nib),
    .cur_operand (cur_operand),
    .is_pfix     (is_pfix),
    .is_nfix     (is_nfix),
    .stack_op    (stack_op),
    .push_sel    (push_sel),
    .opr_hit     (opr_hit),
    .bad_code    (bad_code)
  );

  nsd_stack #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (stack_op),
    .push_val (push_val),
    .levels   (levels)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ip_q   <= START_ADDR;
      fire_q <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      if (instr_valid) ip_q <= ip_q + ADDR_W'(1);
      fire_q <= opr_hit;
      bad_q  <= bad_code;
    end
  end

  assign ip            = ip_q;
  assign reg_a         = levels[0];
  assign reg_b         = levels[1];
  assign reg_c         = levels[2];
  assign indirect_fire = fire_q;
  assign illegal_op    = bad_q;

endmodule

// File: rtl/nsd_checks.sv
module nsd_checks #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              instr_valid,
  input logic [ADDR_W-1:0] ip,
  input logic [WORD_W-1:0] reg_a,
  input logic [WORD_W-1:0] reg_b,
  input logic [WORD_W-1:0] reg_c,
  input logic              indirect_fire,
  input logic              illegal_op,
  input logic              push_en,
  input logic              swap_en,
  input logic              is_prefix,
  input logic [WORD_W-1:0] oreg_q
);

  assert_ip_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |=> ip == $past(ip) + ADDR_W'(1));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> ($stable(ip) && $stable(reg_a) && $stable(reg_b)
                      && $stable(reg_c) && !indirect_fire && !illegal_op));

  assert_push_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |=> (reg_b == $past(reg_a) && reg_c == $past(reg_b)));

  assert_operand_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !is_prefix) |=> oreg_q == '0);

  assert_swap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    swap_en |=> (reg_a == $past(reg_b) && reg_b == $past(reg_a) && $stable(reg_c)));

  assert_illegal_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> (reg_a == $past(reg_a) && reg_b == $past(reg_b)
                    && reg_c == $past(reg_c) && $past(instr_valid)));

  assert_single_action_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push_en, swap_en, is_prefix}));

  assert_prefix_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    is_prefix |=> ($stable(reg_a) && $stable(reg_b) && $stable(reg_c)
                   && !indirect_fire && !illegal_op));

endmodule

bind nibble_stack_decoder nsd_checks #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_checks (
  .clk           (clk),
  .rst_n         (rst_n),
  .instr_valid   (instr_valid),
  .ip            (ip),
  .reg_a         (reg_a),
  .reg_b         (reg_b),
  .reg_c         (reg_c),
  .indirect_fire (indirect_fire),
  .illegal_op    (illegal_op),
  .push_en       (push_en),
  .swap_en       (swap_en),
  .is_prefix     (is_prefix),
  .oreg_q        (oreg_q)
);

// File: tb/sim_nibble_stack_decoder.sv
`timescale 1ns/1ps
module sim_nibble_stack_decoder;

  localparam logic [31:0] START = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  instr_byte = 8'h00;
  logic        instr_valid = 1'b0;
  logic [31:0] ip, reg_a, reg_b, reg_c;
  logic        indirect_fire, illegal_op;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  nibble_stack_decoder #(.START_ADDR(START)) u0 (
    .clk(clk), .rst_n(rst_n), .instr_byte(instr_byte), .instr_valid(instr_valid),
    .ip(ip), .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c),
    .indirect_fire(indirect_fire), .illegal_op(illegal_op)
  );

  // reference state
  logic [31:0] m_ip, m_a, m_b, m_c, m_o;

  logic [129:0] exp_q[$];
  string        req_q[$];

  function automatic logic [129:0] pack_exp(input logic f, input logic i);
    return {m_ip, m_a, m_b, m_c, f, i};
  endfunction

  task automatic compare(input logic [129:0] e, input string req);
    logic [129:0] got;
    got = {ip, reg_a, reg_b, reg_c, indirect_fire, illegal_op};
    checks++;
    if (got !== e) begin
      fails++;
      $display("FAIL %s: ip/a/b/c/fire/ill actual %h %h %h %h %b %b expected %h %h %h %h %b %b",
               req, got[129:98], got[97:66], got[65:34], got[33:2], got[1], got[0],
               e[129:98], e[97:66], e[65:34], e[33:2], e[1], e[0]);
    end
  endtask

  task automatic model_push(input logic [31:0] v);
    m_c = m_b;
    m_b = m_a;
    m_a = v;
  endtask

  task automatic issue(input logic [7:0] b, input string req);
    logic [31:0] full;
    logic f, il;
    logic [31:0] t;
    f = 1'b0;
    il = 1'b0;
    @(negedge clk);
    instr_byte  = b;
    instr_valid = 1'b1;
    full = (m_o & 32'hFFFF_FFF0) + 32'(b[3:0]);
    m_ip = m_ip + 1;
    case (b[7:4])
      4'h2: m_o = full * 16;
      4'h6: m_o = ~(full * 16);
      4'h4: begin model_push(full); m_o = 0; end
      4'hF: begin
        f = 1'b1;
        if (full == 0) begin t = m_a; m_a = m_b; m_b = t; end
        else if (full == 32'd66) model_push(32'h8000_0000);
        else il = 1'b1;
        m_o = 0;
      end
      default: begin il = 1'b1; m_o = 0; end
    endcase
    @(posedge clk);
    #1;
    instr_valid = 1'b0;
    exp_q.push_back(pack_exp(f, il));
    req_q.push_back(req);
  endtask

  task automatic idle(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      instr_valid = 1'b0;
      instr_byte  = 8'h4F;
      @(posedge clk);
      #1;
      exp_q.push_back(pack_exp(1'b0, 1'b0));
      req_q.push_back(req);
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0) begin
        compare(exp_q.pop_front(), req_q.pop_front());
      end
    end
  end

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    m_ip = START; m_a = 0; m_b = 0; m_c = 0; m_o = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare(pack_exp(1'b0, 1'b0), "R1 reset");

    idle(2, "R2 idle");
    // R3: plain loads, fourth load drops oldest
    issue(8'h45, "R3 ldc 5");
    issue(8'h47, "R3 ldc 7");
    issue(8'h49, "R3 ldc 9");
    issue(8'h43, "R3 ldc 3 drops C");
    // R4: prefix chain
    issue(8'h21, "R11 pfix 1");
    issue(8'h22, "R11 pfix 2");
    issue(8'h43, "R4 ldc -> 0x123");
    // R2: gap inside a prefix chain keeps operand
    issue(8'h23, "R11 pfix 3");
    idle(2, "R2 gap in chain");
    issue(8'h41, "R2 R4 ldc -> 0x31");
    // R5 negative prefix
    issue(8'h60, "R11 nfix 0");
    issue(8'h45, "R5 ldc -> FFFFFFF5");
    issue(8'h61, "R11 nfix 1");
    issue(8'h40, "R5 ldc -> FFFFFFE0");
    issue(8'h21, "R11 pfix 1");
    issue(8'h62, "R11 nfix 2");
    issue(8'h43, "R5 mixed chain");
    // R6 operand cleared after ldc
    issue(8'h4A, "R6 ldc A after ldc");
    // R7 swap
    issue(8'hF0, "R7 swap");
    issue(8'h46, "R6 ldc after opr");
    // R8 mint
    issue(8'h24, "R11 pfix 4");
    issue(8'hF2, "R8 mint");
    // R10 undefined indirect
    issue(8'hF5, "R10 opr 5 undefined");
    issue(8'h27, "R11 pfix 7");
    issue(8'hF0, "R10 opr 0x70 undefined");
    issue(8'h41, "R6 ldc after bad opr");
    // R9 undefined direct
    issue(8'h1A, "R9 code 1 undefined");
    issue(8'h2F, "R11 pfix F");
    issue(8'h83, "R9 code 8 after prefix");
    issue(8'h42, "R6 ldc after bad direct");
    idle(1, "R2 flags drop");
    issue(8'hF0, "R7 second swap");
    idle(2, "R2 tail");

    wait (exp_q.size() == 0);
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule